// File: doc/BRIEF.md
# Four-Phase Clock-Domain Word Bridge

This block carries one multi-bit word at a time from a sending clock domain into a receiving clock domain. The two clocks may have any frequency or phase relationship. The data bits never pass through synchronizers of their own. The sender parks the word in a holding register that drives a shared bus, and only afterwards raises a request line. The receiver sees that request through a flip-flop chain, and by then the bus has been stable for several of its own clock periods. It captures the bus, pulses an output valid, and answers with an acknowledge line that crosses back through a second flip-flop chain. Request and acknowledge then both return to zero before the next word may start.

On the sending side a valid/ready pair hands words in. On the receiving side a one-cycle valid pulse hands words out. A receiver-side permission input can hold off both the capture of a new word and the release of the acknowledge. Each side has its own active-low reset.

Top module: `xdom_word_bridge`

## Requirements
- R1: A word is taken in on a sending clock edge where `snd_valid` and `snd_ready` are both high. `snd_ready` is low in the cycle after such an acceptance.
- R2: The accepted word is held in a sender-side register that drives the bus. The request line rises only in a later cycle than the one that loads the register. The register does not change while the request is high, so changes on `snd_data` after acceptance have no effect on the word delivered.
- R3: The receiver observes the request only through a chain of `SYNC_STAGES` flip-flops (at least two). On capture it raises `rcv_valid` for exactly one receiving clock cycle, with the captured word on `rcv_data`. With `HOLD_OUTPUT` = 1, `rcv_data` keeps that word until the next capture. With `HOLD_OUTPUT` = 0, `rcv_data` reads zero outside the valid cycle.
- R4: The acknowledge line rises only in the cycle after the capture.
- R5: The sender lowers the request only after its synchronized copy of the acknowledge is high. It does not raise the request again, or report `snd_ready`, until that copy has gone low. So `snd_ready` is never high while a word is in flight.
- R6: The receiver lowers the acknowledge only once its synchronized request is low and `rcv_ready` is high. While `rcv_ready` stays low after a delivery, `snd_ready` stays low.
- R7: While `rcv_ready` is low, no new word is captured and `rcv_valid` stays low. The pending word is delivered once `rcv_ready` returns high.
- R8: The resets `snd_rst_n` and `rcv_rst_n` act independently. After reset the request and acknowledge are low, `snd_ready` is high and `rcv_valid` is low.
- R9: Every accepted word is delivered exactly once, in acceptance order and with every bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending domain clock |
| snd_rst_n | input | 1 | Sending domain reset, active low |
| snd_data | input | WIDTH | Word offered by the sender |
| snd_valid | input | 1 | Sender offers a word |
| snd_ready | output | 1 | Bridge is idle and can take a word |
| rcv_clk | input | 1 | Receiving domain clock |
| rcv_rst_n | input | 1 | Receiving domain reset, active low |
| rcv_ready | input | 1 | Receiver permits capture and acknowledge release |
| rcv_data | output | WIDTH | Delivered word |
| rcv_valid | output | 1 | One-cycle pulse marking a delivered word |

## Verification
Two events can land on the same receiving clock edge: the moment the synchronized request arrives, or the moment the acknowledge is due to fall, and the receiver withdrawing `rcv_ready`. The bench provokes this by dropping `rcv_ready` at the first sample after a valid pulse. It also toggles `rcv_ready` in a fixed one-in-three pattern while words stream, so the permission edge sweeps across every handshake phase. The outcome is judged at the ports. `snd_ready` must stay low for as long as the release is withheld. A withheld capture must produce no pulse. Every word must still leave once, in order and intact, checked against a queue of accepted words.

// File: rtl/xdom_bridge_pkg.sv
`timescale 1ns/1ps
package xdom_bridge_pkg;

   typedef enum logic [1:0] {
      SND_IDLE  = 2'd0,
      SND_LOAD  = 2'd1,
      SND_REQ   = 2'd2,
      SND_DRAIN = 2'd3
   } snd_state_e;

   typedef enum logic [1:0] {
      RCV_IDLE = 2'd0,
      RCV_CAPT = 2'd1,
      RCV_ACK  = 2'd2
   } rcv_state_e;

   localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/xdom_sync_chain.sv
`timescale 1ns/1ps
module xdom_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   import xdom_bridge_pkg::*;

   localparam int LAST = STAGES - 1;

   if (STAGES < MIN_SYNC_STAGES) begin : g_bad_stages
      $error("xdom_sync_chain: STAGES must be at least 2");
   end

   logic [LAST:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[LAST];

endmodule

// File: rtl/xdom_send_ctl.sv
`timescale 1ns/1ps
module xdom_send_ctl #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             ack_async,
   output logic             req_o,
   output logic [WIDTH-1:0] bus_o
);
   import xdom_bridge_pkg::*;

   snd_state_e       st_q;
   logic             req_q;
   logic [WIDTH-1:0] hold_q;
   logic             ack_s;

   // single synchronization point for the returning acknowledge
   xdom_sync_chain #(.STAGES(STAGES)) i_ack_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (ack_async),
      .q_sync  (ack_s)
   );

   assign in_ready = (st_q == SND_IDLE) && !req_q && !ack_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SND_IDLE;
         req_q  <= 1'b0;
         hold_q <= '0;
      end else begin
         unique case (st_q)
            SND_IDLE: begin
               if (in_valid && in_ready) begin
                  hold_q <= in_data;
                  st_q   <= SND_LOAD;
               end
            end
            SND_LOAD: begin
               req_q <= 1'b1;
               st_q  <= SND_REQ;
            end
            SND_REQ: begin
               if (ack_s) begin
                  req_q <= 1'b0;
                  st_q  <= SND_DRAIN;
               end
            end
            SND_DRAIN: begin
               if (!ack_s) st_q <= SND_IDLE;
            end
            default: st_q <= SND_IDLE;
         endcase
      end
   end

   assign req_o = req_q;
   assign bus_o = hold_q;

   p_accept_closes_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> !in_ready);
   p_bus_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_q |-> $stable(hold_q));
   p_req_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_q) |-> $past(ack_s));
   p_req_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_q) |-> !$past(ack_s));

endmodule

// File: rtl/xdom_recv_ctl.sv
`timescale 1ns/1ps
module xdom_recv_ctl #(
   parameter int WIDTH       = 32,
   parameter int STAGES      = 2,
   parameter bit HOLD_OUTPUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_async,
   input  logic [WIDTH-1:0] bus_i,
   input  logic             out_ready,
   output logic [WIDTH-1:0] out_data,
   output logic             out_valid,
   output logic             ack_o
);
   import xdom_bridge_pkg::*;

   rcv_state_e       st_q;
   logic             ack_q;
   logic             vld_q;
   logic [WIDTH-1:0] cap_q;
   logic             req_s;

   // single synchronization point for the incoming request
   xdom_sync_chain #(.STAGES(STAGES)) i_req_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (req_async),
      .q_sync  (req_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= RCV_IDLE;
         ack_q <= 1'b0;
         vld_q <= 1'b0;
         cap_q <= '0;
      end else begin
         vld_q <= 1'b0;
         unique case (st_q)
            RCV_IDLE: begin
               if (req_s && out_ready) begin
                  cap_q <= bus_i;
                  vld_q <= 1'b1;
                  st_q  <= RCV_CAPT;
               end
            end
            RCV_CAPT: begin
               ack_q <= 1'b1;
               st_q  <= RCV_ACK;
            end
            RCV_ACK: begin
               if (!req_s && out_ready) begin
                  ack_q <= 1'b0;
                  st_q  <= RCV_IDLE;
               end
            end
            default: st_q <= RCV_IDLE;
         endcase
      end
   end

   if (HOLD_OUTPUT) begin : g_hold
      assign out_data = cap_q;
   end else begin : g_mask
      assign out_data = vld_q ? cap_q : '0;
   end

   assign out_valid = vld_q;
   assign ack_o     = ack_q;

   p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |=> !vld_q);
   p_ack_after_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_q) |-> $past(vld_q));
   p_ack_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_q) |-> (!$past(req_s) && $past(out_ready)));
   p_capture_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_q) |-> $past(out_ready));

endmodule

// File: rtl/xdom_word_bridge.sv
`timescale 1ns/1ps
module xdom_word_bridge #(
   parameter int WIDTH       = 32,
   parameter int SYNC_STAGES = 2,
   parameter bit HOLD_OUTPUT = 1'b1
) (
   input  logic             snd_clk,
   input  logic             snd_rst_n,
   input  logic [WIDTH-1:0] snd_data,
   input  logic             snd_valid,
   output logic             snd_ready,
   input  logic             rcv_clk,
   input  logic             rcv_rst_n,
   input  logic             rcv_ready,
   output logic [WIDTH-1:0] rcv_data,
   output logic             rcv_valid
);

   if (WIDTH < 1) begin : g_bad_width
      $error("xdom_word_bridge: WIDTH must be at least 1");
   end

   logic             req_x;
   logic             ack_x;
   logic [WIDTH-1:0] bus_x;

   xdom_send_ctl #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_send (
      .clk       (snd_clk),
      .rst_n     (snd_rst_n),
      .in_data   (snd_data),
      .in_valid  (snd_valid),
      .in_ready  (snd_ready),
      .ack_async (ack_x),
      .req_o     (req_x),
      .bus_o     (bus_x)
   );

   xdom_recv_ctl #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES), .HOLD_OUTPUT(HOLD_OUTPUT)) i_recv (
      .clk       (rcv_clk),
      .rst_n     (rcv_rst_n),
      .req_async (req_x),
      .bus_i     (bus_x),
      .out_ready (rcv_ready),
      .out_data  (rcv_data),
      .out_valid (rcv_valid),
      .ack_o     (ack_x)
   );

endmodule

// File: tb/test_xdom_word_bridge.sv
`timescale 1ns/1ps
module test_xdom_word_bridge;
   localparam int W = 16;

   logic         snd_clk = 1'b0;
   logic         rcv_clk = 1'b0;
   logic         snd_rst_n, rcv_rst_n;
   logic [W-1:0] snd_data;
   logic         snd_valid;
   logic         snd_ready;
   logic         rcv_ready;
   logic [W-1:0] rcv_data;
   logic         rcv_valid;

   always #2.5  snd_clk = ~snd_clk;
   always #3.65 rcv_clk = ~rcv_clk;

   xdom_word_bridge #(.WIDTH(W), .SYNC_STAGES(2), .HOLD_OUTPUT(1'b1)) i_xdom_word_bridge (
      .snd_clk   (snd_clk),
      .snd_rst_n (snd_rst_n),
      .snd_data  (snd_data),
      .snd_valid (snd_valid),
      .snd_ready (snd_ready),
      .rcv_clk   (rcv_clk),
      .rcv_rst_n (rcv_rst_n),
      .rcv_ready (rcv_ready),
      .rcv_data  (rcv_data),
      .rcv_valid (rcv_valid)
   );

   int           n_run  = 0;
   int           n_fail = 0;
   int           sent = 0;
   int           delivered = 0;
   logic [W-1:0] exp_q[$];
   logic         prev_v = 1'b0;
   bit           tog_en = 1'b0;
   int           tog_cnt = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // receiving-side reference: queue of accepted words
   always @(negedge rcv_clk) begin
      if (rcv_rst_n) begin
         if (rcv_valid) begin
            if (prev_v) chk(1'b0, "R3 valid longer than one cycle", 32'd2, 32'd1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R9 word without acceptance", {16'd0, rcv_data}, 32'd0);
            end else begin
               logic [W-1:0] e;
               e = exp_q.pop_front();
               chk(rcv_data == e, "R9 delivered word", {16'd0, rcv_data}, {16'd0, e});
            end
            delivered++;
         end
         prev_v = rcv_valid;
         if (tog_en) begin
            tog_cnt++;
            rcv_ready = (tog_cnt % 3) != 0;
         end
      end
   end

   // sending-side reference: ready must stay low while a word is in flight
   always @(negedge snd_clk) begin
      if (snd_rst_n && snd_ready && (sent != delivered))
         chk(1'b0, "R5 ready while in flight", 32'd1, 32'd0);
   end

   task automatic send(input logic [W-1:0] w);
      @(negedge snd_clk);
      snd_data  = w;
      snd_valid = 1'b1;
      while (!snd_ready) @(negedge snd_clk);
      exp_q.push_back(w);
      @(negedge snd_clk);
      sent++;
      snd_valid = 1'b0;
      snd_data  = ~w;   // later changes must not reach the receiver (R2)
      chk(snd_ready == 1'b0, "R1 ready after accept", {31'd0, snd_ready}, 32'd0);
   endtask

   task automatic wait_done();
      for (int k = 0; k < 5000 && delivered != sent; k++) @(negedge snd_clk);
   endtask

   initial begin
      snd_rst_n = 1'b0; rcv_rst_n = 1'b0;
      snd_valid = 1'b0; snd_data = '0; rcv_ready = 1'b1;
      repeat (4) @(negedge snd_clk);
      snd_rst_n = 1'b1;
      repeat (3) @(negedge rcv_clk);
      rcv_rst_n = 1'b1;
      @(negedge snd_clk);
      chk(snd_ready == 1'b1, "R8 ready after reset", {31'd0, snd_ready}, 32'd1);
      @(negedge rcv_clk);
      chk(rcv_valid == 1'b0, "R8 valid after reset", {31'd0, rcv_valid}, 32'd0);

      // corner words
      send(16'h0000); send(16'hFFFF); send(16'h5555);
      send(16'hAAAA); send(16'h0001); send(16'h8000);
      wait_done();
      chk(rcv_data == 16'h8000, "R3 output holds last word", {16'd0, rcv_data}, 32'h8000);

      // streamed words
      for (int i = 0; i < 30; i++) send(W'(i * 16'h9E37) ^ W'(i << 3));
      wait_done();
      chk(delivered == sent, "R9 stream count", delivered, sent);

      // withheld acknowledge release
      send(16'h1234);
      while (delivered != sent) @(negedge rcv_clk);
      rcv_ready = 1'b0;
      repeat (40) @(negedge snd_clk);
      chk(snd_ready == 1'b0, "R6 ready held while release withheld", {31'd0, snd_ready}, 32'd0);
      @(negedge rcv_clk);
      rcv_ready = 1'b1;
      for (int k = 0; k < 100 && !snd_ready; k++) @(negedge snd_clk);
      chk(snd_ready == 1'b1, "R6 ready after release", {31'd0, snd_ready}, 32'd1);

      // withheld capture
      begin
         int d0;
         @(negedge rcv_clk);
         rcv_ready = 1'b0;
         d0 = delivered;
         send(16'hC3A5);
         repeat (40) @(negedge rcv_clk);
         chk(delivered == d0, "R7 no capture while held", delivered, d0);
         rcv_ready = 1'b1;
         wait_done();
         chk(delivered == d0 + 1, "R7 capture after permission", delivered, d0 + 1);
      end

      // permission toggling across all handshake phases
      tog_en = 1'b1;
      for (int i = 0; i < 20; i++) send(W'(16'h0F0F + i * 16'h0101));
      wait_done();
      tog_en = 1'b0;
      @(negedge rcv_clk);
      rcv_ready = 1'b1;

      chk(exp_q.size() == 0, "R9 nothing left undelivered", exp_q.size(), 32'd0);
      chk(delivered == sent, "R9 total once each", delivered, sent);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge snd_clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule